// File: doc/BRIEF.md
# Subsampled SAD accumulation unit

This unit measures how well one candidate macro-block matches the current macro-block. It forms the sum of absolute differences (SAD) between the two blocks. A pixel source feeds it one pair of pixels per clock: one from the current block and the pixel at the same position in the candidate block. The source sends the pairs in raster order, row by row and column by column inside each row. Each accepted pair adds the magnitude of its difference to a running total. When the block is complete, the total is held on the result output and a one-cycle completion strobe fires.

A start pulse opens a new block. It clears the total, and a pair presented in the same cycle counts as the first pair of the block. The mode bit is captured with the start pulse. Full mode sums every row of the N×N block. Row-subsampled mode sums only the even-indexed rows, which halves the number of difference terms per candidate. In that mode the source may still present the odd rows: those pairs are accepted and counted for position but add nothing. The block is complete after the last pixel of the last even row. Fetching pixels from the search window and ranking candidates are done by neighbouring blocks.

Top module: `sad_accum_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `sad_o` is 0 and `done_o` is 0.
- R2: In full mode (`sub_mode_i` = 0 at start), after N×N accepted pairs `sad_o` equals the sum of |cur − cand| over all of them. `done_o` is 1 in the cycle right after the clock edge that captures pair N×N−1, and `sad_o` already holds the final value in that cycle.
- R3: The magnitude does not depend on which pixel is larger. Pixels are 8-bit unsigned, so a block of all pairs cur=0, cand=255 and a block of all pairs cur=255, cand=0 both give 65280 for N=16.
- R4: In subsampled mode (`sub_mode_i` = 1 at start), pair k of the block has row index floor(k/N). Only even rows are summed. `done_o` rises in the cycle after pair (N−1)×N−1 is captured, which is the last pixel of row N−2.
- R5: In subsampled mode, pairs on odd rows leave `sad_o` unchanged. After row 1 has been sent, `sad_o` equals the row-0 sum.
- R6: A start pulse clears the total at its clock edge. If `pix_vld_i` is high in the start cycle, that pair is pair 0 of the new block. A start pulse with no pair leaves `sad_o` = 0.
- R7: Cycles with `pix_vld_i` low between pairs have no effect on the result or on the position count.
- R8: After a block completes, pairs presented before the next start are ignored. `sad_o` keeps its value and `done_o` stays 0.
- R9: A start pulse in the middle of a block abandons it. The new block's result depends only on its own pairs.
- R10: `done_o` is high for exactly one cycle per completed block.
- R11: `sub_mode_i` is used only in the start cycle. Changing it during a block does not affect that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a new block; clears the total |
| sub_mode_i | input | 1 | 0 = full block, 1 = even rows only; sampled with start_i |
| pix_vld_i | input | 1 | A pixel pair is present this cycle |
| cur_pix_i | input | 8 | Current-block pixel |
| cand_pix_i | input | 8 | Candidate-block pixel |
| sad_o | output | 16 | Running / final SAD |
| done_o | output | 1 | One-cycle strobe when the block is complete |

## Verification
Every pair reaches `sad_o` one clock edge after it is presented, and `done_o` rises at that same edge for the final pair. The bench drives inputs on the falling edge and samples at the next falling edge, one edge after the pair of interest is captured.

The bench checks the following, each at that sampling point:
- The completion strobe and the final total at the sample right after the last pair.
- That the strobe has dropped one sample later.
- The cleared total right after a start-only cycle.
- The row-0 partial sum right after the last pair of row 1 in subsampled mode.

Gap cycles do not move any of these sample points relative to the counted pairs.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic {
    SAD_MODE_FULL = 1'b0,
    SAD_MODE_SUB  = 1'b1
  } sad_mode_e;

endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  output logic [PIX_W-1:0] mag_o
);

  // Subtract the smaller operand from the larger one, so the result is never negative
  always_comb begin
    if (a_i >= b_i) mag_o = a_i - b_i;
    else            mag_o = b_i - a_i;
  end

endmodule

// File: rtl/sad_pos_track.sv
module sad_pos_track
  import sad_pkg::*;
#(
  parameter int BLK_N = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      pix_vld_i,
  input  sad_mode_e mode_i,
  output logic      take_o,
  output logic      use_o,
  output logic      last_o
);

  localparam int CW = (BLK_N > 1) ? $clog2(BLK_N) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(BLK_N - 1);
  localparam logic [CW-1:0] LAST_EVEN_ROW = CW'(BLK_N - 2);

  logic            busy_q, busy_d;
  logic [CW-1:0]   row_q, row_d, col_q, col_d;
  sad_mode_e       mode_q, mode_d;
  logic [CW-1:0]   row_cur, col_cur;
  sad_mode_e       mode_cur;
  logic            row_end, pos_en;

  always_comb begin
    row_cur  = start_i ? '0 : row_q;
    col_cur  = start_i ? '0 : col_q;
    mode_cur = start_i ? mode_i : mode_q;
    take_o   = pix_vld_i & (start_i | busy_q);
    row_end  = (col_cur == LAST_IDX);
    use_o    = take_o & ((mode_cur == SAD_MODE_FULL) | ~row_cur[0]);
    if (mode_cur == SAD_MODE_SUB)
      last_o = take_o & row_end & (row_cur == LAST_EVEN_ROW);
    else
      last_o = take_o & row_end & (row_cur == LAST_IDX);
  end

  always_comb begin
    busy_d = start_i | busy_q;
    row_d  = row_cur;
    col_d  = col_cur;
    mode_d = mode_cur;
    if (take_o) begin
      if (row_end) begin
        col_d = '0;
        row_d = row_cur + 1'b1;
      end else begin
        col_d = col_cur + 1'b1;
      end
    end
    if (last_o) busy_d = 1'b0;
  end

  assign pos_en = start_i | take_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      mode_q <= SAD_MODE_FULL;
    end else if (pos_en) begin
      busy_q <= busy_d;
      row_q  <= row_d;
      col_q  <= col_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [PIX_W-1:0] term_i,
  output logic [SAD_W-1:0] acc_o
);

  logic [SAD_W-1:0] acc_q, acc_d, base, addend;
  logic             acc_en;

  always_comb begin
    base   = clr_i ? '0 : acc_q;
    addend = add_i ? {{(SAD_W-PIX_W){1'b0}}, term_i} : '0;
    acc_d  = base + addend;
    acc_en = clr_i | add_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/sad_accum_unit.sv
module sad_accum_unit
  import sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK_N = 16,
  parameter int SAD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sub_mode_i,
  input  logic             pix_vld_i,
  input  logic [PIX_W-1:0] cur_pix_i,
  input  logic [PIX_W-1:0] cand_pix_i,
  output logic [SAD_W-1:0] sad_o,
  output logic             done_o
);

  logic             pix_take, pix_use, blk_last;
  logic [PIX_W-1:0] diff_mag;
  logic             done_q;

  sad_pos_track #(.BLK_N(BLK_N)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pix_vld_i (pix_vld_i),
    .mode_i    (sad_mode_e'(sub_mode_i)),
    .take_o    (pix_take),
    .use_o     (pix_use),
    .last_o    (blk_last)
  );

  sad_absdiff #(.PIX_W(PIX_W)) u_abs (
    .a_i   (cur_pix_i),
    .b_i   (cand_pix_i),
    .mag_o (diff_mag)
  );

  sad_accum #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .add_i  (pix_use),
    .term_i (diff_mag),
    .acc_o  (sad_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= blk_last;
  end

  assign done_o = done_q;

endmodule

// File: rtl/sad_accum_chk.sv
module sad_accum_chk #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             pix_take,
  input logic             pix_use,
  input logic [SAD_W-1:0] sad_o,
  input logic             done_o
);

  localparam logic [SAD_W-1:0] MAX_STEP = SAD_W'((1 << PIX_W) - 1);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !pix_use) |=> (sad_o == '0));

  p_odd_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_take && !pix_use && !start_i) |=> $stable(sad_o));

  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_use && !start_i) |=> ((sad_o >= $past(sad_o)) && ((sad_o - $past(sad_o)) <= MAX_STEP)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_take && !start_i) |=> $stable(sad_o));

endmodule

bind sad_accum_unit sad_accum_chk #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .pix_take (pix_take),
  .pix_use  (pix_use),
  .sad_o    (sad_o),
  .done_o   (done_o)
);

// File: tb/sad_accum_unit_test.sv
module sad_accum_unit_test;

  localparam int N  = 16;
  localparam int NN = N * N;

  logic       clk, rst_n, start_i, sub_mode_i, pix_vld_i;
  logic [7:0] cur_pix_i, cand_pix_i;
  logic [15:0] sad_o;
  logic       done_o;

  logic [7:0] cur_m  [NN];
  logic [7:0] cand_m [NN];

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  sad_accum_unit #(.PIX_W(8), .BLK_N(N), .SAD_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_mode_i(sub_mode_i),
    .pix_vld_i(pix_vld_i), .cur_pix_i(cur_pix_i), .cand_pix_i(cand_pix_i),
    .sad_o(sad_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_sad(input bit sub, input int nrows);
    int s = 0;
    for (int r = 0; r < nrows; r++) begin
      if (!(sub && r[0])) begin
        for (int c = 0; c < N; c++) begin
          int a = int'(cur_m[r*N+c]);
          int b = int'(cand_m[r*N+c]);
          s += (a > b) ? a - b : b - a;
        end
      end
    end
    return s;
  endfunction

  task automatic fill_random();
    for (int k = 0; k < NN; k++) begin
      cur_m[k]  = 8'($urandom);
      cand_m[k] = 8'($urandom);
    end
  endtask

  // Called right after a falling edge
  task automatic run_block(input bit sub, input bit merged, input bit gaps);
    int  npairs = sub ? (N - 1) * N : NN;
    int  k = 0;
    bit  row_chk = 0;
    int  exp_sad = ref_sad(sub, N);
    if (!merged) begin
      start_i = 1; sub_mode_i = sub; pix_vld_i = 0;
      @(negedge clk);
      start_i = 0;
      check("R6 start-only clears", int'(sad_o), 0);
    end
    while (k < npairs) begin
      if (gaps && k > 0 && ($urandom % 4) == 0) begin
        start_i = 0; pix_vld_i = 0;
        cur_pix_i = 8'($urandom); cand_pix_i = 8'($urandom);
        sub_mode_i = 1'($urandom);
      end else begin
        if (merged && k == 0) begin
          start_i = 1; sub_mode_i = sub;
        end else begin
          start_i = 0; sub_mode_i = 1'($urandom);  // R11 mode changes mid-block
        end
        pix_vld_i = 1; cur_pix_i = cur_m[k]; cand_pix_i = cand_m[k];
        k++;
      end
      @(negedge clk);
      if (sub && k == 2 * N && !row_chk) begin
        row_chk = 1;
        check("R5 odd row adds nothing", int'(sad_o), ref_sad(1, 2));
      end
    end
    start_i = 0; pix_vld_i = 0;
    check(sub ? "R4 done after last even row" : "R2 done after last pair", int'(done_o), 1);
    check(sub ? "R4 subsampled SAD" : "R2 full SAD", int'(sad_o), exp_sad);
    @(negedge clk);
    check("R10 done single cycle", int'(done_o), 0);
    // R8 pairs after completion are ignored
    for (int e = 0; e < 5; e++) begin
      pix_vld_i = 1; cur_pix_i = 8'($urandom); cand_pix_i = 8'($urandom);
      @(negedge clk);
      if (done_o) check("R8 no done after completion", 1, 0);
    end
    pix_vld_i = 0;
    check("R8 result holds after completion", int'(sad_o), exp_sad);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; start_i = 1; sub_mode_i = 0; pix_vld_i = 1;
    cur_pix_i = 8'd200; cand_pix_i = 8'd3;
    repeat (3) @(negedge clk);
    check("R1 sad in reset", int'(sad_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    start_i = 0; pix_vld_i = 0;
    rst_n = 1;
    @(negedge clk);
    check("R1 sad after reset", int'(sad_o), 0);
    check("R1 done after reset", int'(done_o), 0);

    fill_random(); run_block(0, 1, 0);            // R2
    fill_random(); run_block(0, 0, 1);            // R2 R6 R7
    fill_random(); run_block(1, 1, 1);            // R4 R5 R7 R11
    fill_random(); run_block(1, 0, 0);            // R4

    // R3 candidate larger than current
    for (int k = 0; k < NN; k++) begin cur_m[k] = 8'd0; cand_m[k] = 8'd255; end
    run_block(0, 1, 0);
    check("R3 cand>cur total", int'(sad_o), 65280);
    // R3 current larger than candidate
    for (int k = 0; k < NN; k++) begin cur_m[k] = 8'd255; cand_m[k] = 8'd0; end
    run_block(0, 0, 1);
    check("R3 cur>cand total", int'(sad_o), 65280);

    // R5 even rows match exactly, odd rows differ maximally
    for (int k = 0; k < NN; k++) begin
      cur_m[k]  = ((k / N) % 2 == 1) ? 8'd0 : 8'($urandom);
      cand_m[k] = ((k / N) % 2 == 1) ? 8'd255 : cur_m[k];
    end
    run_block(1, 1, 0);
    check("R5 only odd rows differ", int'(sad_o), 0);

    // R9 restart in the middle of a block
    start_i = 1; sub_mode_i = 0;
    for (int k = 0; k < 37; k++) begin
      pix_vld_i = 1; cur_pix_i = 8'd255; cand_pix_i = 8'd0;
      @(negedge clk);
      start_i = 0;
    end
    fill_random(); run_block(0, 1, 0);
    check("R9 restarted block result", int'(sad_o), ref_sad(0, N));
    start_i = 1; sub_mode_i = 1; pix_vld_i = 1; cur_pix_i = 8'd9; cand_pix_i = 8'd1;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      start_i = 0;
    end
    fill_random(); run_block(0, 0, 1);
    check("R9 restart sub to full", int'(sad_o), ref_sad(0, N));

    for (int t = 0; t < 8; t++) begin
      fill_random();
      run_block(1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule